// File: doc/BRIEF.md
# SPI Slave Buffered Transfer Engine

This block is an SPI slave that moves bytes between a serial link and two local byte buffers. An external master drives the clock and the active-low select. The transmit buffer holds a programmable number of bytes, and they are shifted out on MISO. The receive buffer holds received bytes up to a programmable capacity. Software fills the transmit buffer through a byte write port and reads received bytes through a byte read port. It marks each buffer ready or empty and arms the engine with a start command. After that, all timing comes from the master's clock; no local bit-rate setting is involved.

The two buffers close independently. The receive buffer closes when select goes inactive or when it reaches capacity. The transmit buffer closes only after its programmed count has been shifted out, and it stays open across select negation. When the master sends more bytes than the receive buffer can hold, an out-of-buffer event is raised. Three sticky event bits are gated by a mask onto a single interrupt line.

Top module: `spis_xfer_engine`

## Requirements
- R1: After reset the command/status, event and mask registers and the receive count read 0, irq is low and MISO is 1.
- R2: Event register (address 1) bits are sticky: bit0 = receive buffer closed, bit1 = transmit buffer closed, bit2 = out-of-buffer. Writing a 1 to a bit clears it, and writing 0xFF clears all of them.
- R3: irq is high exactly when some event bit and the same bit of the mask register (address 2) are both 1.
- R4: Without a start command the engine ignores clocked bytes: the receive count, the stored data and the events do not change, and MISO stays 1.
- R5: SPI mode 0 is used, MSB first. MOSI is captured on the rising SCK edge and MISO changes on the falling edge. Received bytes are stored in arrival order from receive address 0.
- R6: If select goes inactive before the receive buffer is full, the receive buffer closes with the bytes received so far and event bit0 only. Bytes sent later in that arming are not stored.
- R7: When exactly the receive capacity (address 4) has been received, the receive buffer closes full with event bit0, and a following deselect raises no out-of-buffer event.
- R8: The byte after the last one that fits (capacity+1) raises event bit2 while the count stays at capacity.
- R9: The transmit buffer shifts out bytes 0..N-1, where N is the transmit length at address 3. It stays open across deselect and closes with event bit1 after byte N.
- R10: MISO carries 0xFF for every byte clocked when the transmit buffer is not ready or is already exhausted.
- R11: The register map, by 3-bit address: 0 = command on write (bit0 start, bit1 transmit ready, bit2 receive empty) and status on read (bit0 armed, bit1 transmit open, bit2 receive open); 1 = events; 2 = mask; 3 = transmit length; 4 = receive capacity; 5 = receive count (read only). The armed flag clears once both buffers are closed and select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from master |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| txb_we | input | 1 | Transmit buffer write strobe |
| txb_addr | input | AW | Transmit buffer write address |
| txb_wdata | input | 8 | Transmit buffer write byte |
| rxb_addr | input | AW | Receive buffer read address |
| rxb_rdata | output | 8 | Receive buffer read byte |
| irq | output | 1 | Masked event interrupt |

## Verification
Each SCK or select change passes through two synchroniser flops and one edge register. The byte-complete pulse is therefore registered about three system cycles after a pin edge, and the buffer counters and event bits update one cycle after that. irq follows the event register in the same cycle. The bench holds each SCK phase for eight system cycles and waits at least eight cycles after the last edge of a byte or a select change before it reads any register. MISO is sampled just before each rising SCK edge, which leaves more than four cycles after the falling edge that updated it.

// File: rtl/spis_pkg.sv
// Shared constants for the SPI slave transfer engine: register addresses
// and event bit positions. Assumes 8-bit registers and a 3-bit address.
package spis_pkg;
    localparam logic [2:0] RA_CMD   = 3'd0;
    localparam logic [2:0] RA_EVT   = 3'd1;
    localparam logic [2:0] RA_MASK  = 3'd2;
    localparam logic [2:0] RA_TXLEN = 3'd3;
    localparam logic [2:0] RA_RXCAP = 3'd4;
    localparam logic [2:0] RA_RXCNT = 3'd5;

    localparam int EV_RXC = 0;
    localparam int EV_TXC = 1;
    localparam int EV_OVF = 2;
    localparam int NEV    = 3;
endpackage

// File: rtl/spis_sync.sv
// Two-flop synchroniser for a bundle of asynchronous pins.
// Assumes the bits of the bundle change far apart compared with clk.
module spis_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit toward the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spis_shift.sv
// Mode-0 byte shifter. Detects SCK and select edges in the clk domain,
// shifts MOSI in on rising SCK and shifts MISO out on falling SCK, MSB first.
// Assumes SCK runs at no more than a quarter of clk, so that tx_byte has
// been updated for the next byte before the falling edge that loads it.
module spis_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       sel_n_s,
    input  logic       mosi_s,
    input  logic       enable,
    input  logic [7:0] tx_byte,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       miso,
    output logic       sess_start,
    output logic       sess_end
);
    logic       sck_q, sel_q;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sh, tx_sh;
    logic       sck_rise, sck_fall;

    assign sck_rise   = sck_s & ~sck_q;
    assign sck_fall   = ~sck_s & sck_q;
    assign sess_start = sel_q & ~sel_n_s;
    assign sess_end   = ~sel_q & sel_n_s;
    assign rx_byte    = rx_sh;
    assign miso       = tx_sh[7];

    // Edge history, bit counting and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q     <= 1'b0;
            sel_q     <= 1'b1;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= 8'hFF;
            byte_done <= 1'b0;
        end else begin
            sck_q     <= sck_s;
            sel_q     <= sel_n_s;
            byte_done <= 1'b0;
            if (sel_n_s) begin
                bit_cnt <= '0;
                tx_sh   <= 8'hFF;
            end else if (sess_start) begin
                bit_cnt <= '0;
                tx_sh   <= enable ? tx_byte : 8'hFF;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[6:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) byte_done <= enable;
            end else if (sck_fall) begin
                if (bit_cnt == 3'd0) tx_sh <= enable ? tx_byte : 8'hFF;
                else                 tx_sh <= {tx_sh[6:0], 1'b1};
            end
        end
    end
endmodule

// File: rtl/spis_bufctl.sv
// Buffer controller: holds both byte buffers, their indices and open flags,
// and the armed state. It closes each buffer on its own rule and pulses
// event strobes. Assumes tx_len and rx_cap lie in 1..DEPTH.
module spis_bufctl #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_start,
    input  logic                    cmd_txrdy,
    input  logic                    cmd_rxempty,
    input  logic [CW-1:0]           tx_len,
    input  logic [CW-1:0]           rx_cap,
    input  logic                    byte_done,
    input  logic [7:0]              rx_byte,
    input  logic                    sess_start,
    input  logic                    sess_end,
    input  logic                    txb_we,
    input  logic [AW-1:0]           txb_addr,
    input  logic [7:0]              txb_wdata,
    input  logic [AW-1:0]           rxb_addr,
    output logic [7:0]              rxb_rdata,
    output logic [7:0]              tx_byte,
    output logic                    armed,
    output logic                    tx_open,
    output logic                    rx_open,
    output logic [CW-1:0]           rx_cnt,
    output logic [spis_pkg::NEV-1:0] ev_set
);
    import spis_pkg::*;

    logic [7:0]    tx_mem [DEPTH];
    logic [7:0]    rx_mem [DEPTH];
    logic [CW-1:0] tx_idx;
    logic          in_sess, ovf_done;
    logic          take;

    assign take      = byte_done & armed;
    assign tx_byte   = tx_open ? tx_mem[tx_idx[AW-1:0]] : 8'hFF;
    assign rxb_rdata = rx_mem[rxb_addr];

    // Transmit buffer storage, filled by software.
    always_ff @(posedge clk) begin
        if (txb_we) tx_mem[txb_addr] <= txb_wdata;
    end

    // Receive buffer storage, filled by completed bytes.
    always_ff @(posedge clk) begin
        if (take && rx_open) rx_mem[rx_cnt[AW-1:0]] <= rx_byte;
    end

    // Arming, buffer open/close rules, counters and event strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            tx_open  <= 1'b0;
            rx_open  <= 1'b0;
            tx_idx   <= '0;
            rx_cnt   <= '0;
            in_sess  <= 1'b0;
            ovf_done <= 1'b0;
            ev_set   <= '0;
        end else begin
            ev_set <= '0;
            if (cmd_start) armed <= 1'b1;
            else if (armed && !rx_open && !tx_open && !in_sess) armed <= 1'b0;
            if (cmd_txrdy) begin
                tx_open <= 1'b1;
                tx_idx  <= '0;
            end
            if (cmd_rxempty) begin
                rx_open  <= 1'b1;
                rx_cnt   <= '0;
                ovf_done <= 1'b0;
            end
            if (sess_start && armed) in_sess <= 1'b1;
            if (take) begin
                if (rx_open) begin
                    rx_cnt <= rx_cnt + CW'(1);
                    if (rx_cnt + CW'(1) == rx_cap) begin
                        rx_open        <= 1'b0;
                        ev_set[EV_RXC] <= 1'b1;
                    end
                end else if (rx_cnt == rx_cap && !ovf_done) begin
                    ovf_done       <= 1'b1;
                    ev_set[EV_OVF] <= 1'b1;
                end
                if (tx_open) begin
                    tx_idx <= tx_idx + CW'(1);
                    if (tx_idx + CW'(1) == tx_len) begin
                        tx_open        <= 1'b0;
                        ev_set[EV_TXC] <= 1'b1;
                    end
                end
            end
            if (sess_end && in_sess) begin
                in_sess <= 1'b0;
                if (rx_open) begin
                    rx_open        <= 1'b0;
                    ev_set[EV_RXC] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spis_regs.sv
// Register file: command decode, sticky write-one-to-clear events, mask,
// length/capacity settings, read mux and interrupt output.
// Assumes CW is at most 8 so settings fit in a register.
module spis_regs #(
    parameter int CW = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [2:0]               reg_addr,
    input  logic [7:0]               reg_wdata,
    output logic [7:0]               reg_rdata,
    input  logic [spis_pkg::NEV-1:0] ev_set,
    input  logic [2:0]               status,
    input  logic [CW-1:0]            rx_cnt,
    output logic                     cmd_start,
    output logic                     cmd_txrdy,
    output logic                     cmd_rxempty,
    output logic [CW-1:0]            tx_len,
    output logic [CW-1:0]            rx_cap,
    output logic [spis_pkg::NEV-1:0] evt,
    output logic [7:0]               mask,
    output logic                     irq
);
    import spis_pkg::*;

    logic             wr_cmd, wr_evt;
    logic [NEV-1:0]   clr;

    assign wr_cmd      = reg_we && (reg_addr == RA_CMD);
    assign wr_evt      = reg_we && (reg_addr == RA_EVT);
    assign cmd_start   = wr_cmd & reg_wdata[0];
    assign cmd_txrdy   = wr_cmd & reg_wdata[1];
    assign cmd_rxempty = wr_cmd & reg_wdata[2];
    assign clr         = wr_evt ? reg_wdata[NEV-1:0] : '0;
    assign irq         = |(evt & mask[NEV-1:0]);

    // Writable settings and sticky events; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt    <= '0;
            mask   <= '0;
            tx_len <= CW'(1);
            rx_cap <= CW'(1);
        end else begin
            evt <= (evt & ~clr) | ev_set;
            if (reg_we && reg_addr == RA_MASK)  mask   <= reg_wdata;
            if (reg_we && reg_addr == RA_TXLEN) tx_len <= reg_wdata[CW-1:0];
            if (reg_we && reg_addr == RA_RXCAP) rx_cap <= reg_wdata[CW-1:0];
        end
    end

    // Read data selection.
    always_comb begin
        case (reg_addr)
            RA_CMD:   reg_rdata = {5'd0, status};
            RA_EVT:   reg_rdata = 8'(evt);
            RA_MASK:  reg_rdata = mask;
            RA_TXLEN: reg_rdata = 8'(tx_len);
            RA_RXCAP: reg_rdata = 8'(rx_cap);
            RA_RXCNT: reg_rdata = 8'(rx_cnt);
            default:  reg_rdata = 8'd0;
        endcase
    end
endmodule

// File: rtl/spis_xfer_engine.sv
// Top of the SPI slave buffered transfer engine: synchroniser, shifter,
// buffer controller and register file. Assumes SCK at most clk/4.
module spis_xfer_engine #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_sel_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          txb_we,
    input  logic [AW-1:0] txb_addr,
    input  logic [7:0]    txb_wdata,
    input  logic [AW-1:0] rxb_addr,
    output logic [7:0]    rxb_rdata,
    output logic          irq
);
    import spis_pkg::*;

    logic          sck_s, sel_n_s, mosi_s;
    logic          byte_done, sess_start, sess_end;
    logic [7:0]    rx_byte, tx_byte;
    logic          armed, tx_open, rx_open;
    logic [CW-1:0] rx_cnt, tx_len, rx_cap;
    logic [NEV-1:0] ev_set, evt;
    logic [7:0]    mask;
    logic          cmd_start, cmd_txrdy, cmd_rxempty;

    spis_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sck, spi_sel_n, spi_mosi}),
        .q({sck_s, sel_n_s, mosi_s})
    );

    spis_shift u_shift (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .sel_n_s(sel_n_s),
        .mosi_s(mosi_s), .enable(armed), .tx_byte(tx_byte),
        .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso),
        .sess_start(sess_start), .sess_end(sess_end)
    );

    spis_bufctl #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start),
        .cmd_txrdy(cmd_txrdy), .cmd_rxempty(cmd_rxempty),
        .tx_len(tx_len), .rx_cap(rx_cap), .byte_done(byte_done),
        .rx_byte(rx_byte), .sess_start(sess_start), .sess_end(sess_end),
        .txb_we(txb_we), .txb_addr(txb_addr), .txb_wdata(txb_wdata),
        .rxb_addr(rxb_addr), .rxb_rdata(rxb_rdata), .tx_byte(tx_byte),
        .armed(armed), .tx_open(tx_open), .rx_open(rx_open),
        .rx_cnt(rx_cnt), .ev_set(ev_set)
    );

    spis_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_set(ev_set),
        .status({rx_open, tx_open, armed}), .rx_cnt(rx_cnt),
        .cmd_start(cmd_start), .cmd_txrdy(cmd_txrdy),
        .cmd_rxempty(cmd_rxempty), .tx_len(tx_len), .rx_cap(rx_cap),
        .evt(evt), .mask(mask), .irq(irq)
    );
endmodule

// File: rtl/spis_xfer_engine_chk.sv
// Property checker for the transfer engine, attached by bind.
module spis_xfer_engine_chk #(
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic [7:0]    reg_wdata,
    input logic [2:0]    evt,
    input logic          irq,
    input logic          armed,
    input logic          rx_open,
    input logic [CW-1:0] rx_cnt
);
    // R2: without a write to the event register no pending bit drops.
    a_r2_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == 3'd1) |=> ((evt & $past(evt)) == $past(evt)));

    // R3: clearing the whole mask silences irq from the next cycle.
    a_r3_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd2 && reg_wdata == 8'd0) |=> !irq);

    // R3: irq is never raised with no event pending.
    a_r3_irq_needs_evt: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (evt != 3'd0));

    // R4: while not armed, only a command can move the receive count.
    a_r4_unarmed_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !(reg_we && reg_addr == 3'd0)) |=> $stable(rx_cnt));

    // R8: an out-of-buffer event only appears with the receive buffer closed.
    a_r8_ovf_closed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt[2]) |-> !rx_open);
endmodule

bind spis_xfer_engine spis_xfer_engine_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt(evt), .irq(irq), .armed(armed),
    .rx_open(rx_open), .rx_cnt(rx_cnt)
);

// File: tb/spis_xfer_engine_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module spis_xfer_engine_tb;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_sck = 1'b0, spi_sel_n = 1'b1, spi_mosi = 1'b0;
    logic          spi_miso;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          txb_we = 1'b0;
    logic [AW-1:0] txb_addr = '0, rxb_addr = '0;
    logic [7:0]    txb_wdata = '0;
    logic [7:0]    rxb_rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    spis_xfer_engine #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_sel_n(spi_sel_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .txb_we(txb_we), .txb_addr(txb_addr), .txb_wdata(txb_wdata),
        .rxb_addr(rxb_addr), .rxb_rdata(rxb_rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rx_at(input int i, output logic [7:0] d);
        @(negedge clk);
        rxb_addr = AW'(i);
        #1 d = rxb_rdata;
    endtask

    task automatic tx_fill(input int i, input logic [7:0] d);
        @(negedge clk);
        txb_we = 1'b1; txb_addr = AW'(i); txb_wdata = d;
        @(negedge clk);
        txb_we = 1'b0;
    endtask

    task automatic sel(input logic v);
        @(negedge clk);
        spi_sel_n = v;
        repeat (12) @(negedge clk);
    endtask

    // Mode-0 master byte: MISO sampled just before each rising SCK.
    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = mo[b];
            repeat (8) @(negedge clk);
            mi[b] = spi_miso;
            spi_sck = 1'b1;
            repeat (8) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(3'd0, d); check("R1 status", d, 0);
        rd(3'd1, d); check("R1 events", d, 0);
        rd(3'd2, d); check("R1 mask", d, 0);
        rd(3'd5, d); check("R1 rx count", d, 0);
        check("R1 irq", irq, 0);
        check("R1 miso", spi_miso, 1);
    endtask

    task automatic t_unarmed;
        logic [7:0] d, mi;
        wr(3'd4, 8'd4);
        wr(3'd0, 8'h04);            // receive empty, no start
        sel(1'b0);
        xfer(8'h5A, mi); check("R4 miso idle ones", mi, 8'hFF);
        xfer(8'hC3, mi); check("R10 miso not armed", mi, 8'hFF);
        sel(1'b1);
        rd(3'd5, d); check("R4 rx count unchanged", d, 0);
        rd(3'd1, d); check("R4 no events", d, 0);
    endtask

    task automatic t_early_deselect;
        logic [7:0] d, mi;
        for (int i = 0; i < 5; i++) tx_fill(i, 8'hA1 + 8'(i));
        wr(3'd3, 8'd5);
        rd(3'd3, d); check("R11 tx length readback", d, 5);
        wr(3'd4, 8'd8);
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h07);
        sel(1'b0);
        xfer(8'h11, mi); check("R9 tx byte0", mi, 8'hA1);
        xfer(8'h22, mi); check("R9 tx byte1", mi, 8'hA2);
        xfer(8'h33, mi); check("R5 R9 tx byte2", mi, 8'hA3);
        sel(1'b1);
        rd(3'd0, d); check("R6 rx closed tx open", d, 8'h03);
        rd(3'd1, d); check("R6 rx close event only", d, 8'h01);
        rd(3'd5, d); check("R6 rx count", d, 3);
        rx_at(0, d); check("R5 rx data0", d, 8'h11);
        rx_at(2, d); check("R5 rx data2", d, 8'h33);
        sel(1'b0);
        xfer(8'h44, mi); check("R9 tx byte3 after reselect", mi, 8'hA4);
        xfer(8'h55, mi); check("R9 tx byte4", mi, 8'hA5);
        rd(3'd1, d); check("R9 tx closed after count", d, 8'h03);
        xfer(8'h66, mi); check("R10 tx exhausted ones", mi, 8'hFF);
        sel(1'b1);
        rd(3'd5, d); check("R6 later bytes not stored", d, 3);
        rd(3'd0, d); check("R11 armed cleared", d, 0);
    endtask

    task automatic t_exact_cap;
        logic [7:0] d, mi;
        wr(3'd1, 8'hFF);
        wr(3'd4, 8'd4);
        wr(3'd0, 8'h05);            // start and receive empty, tx not ready
        sel(1'b0);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h80 + 8'(i), mi);
            check("R10 tx not ready ones", mi, 8'hFF);
        end
        sel(1'b1);
        rd(3'd1, d); check("R7 closed full no error", d, 8'h01);
        rd(3'd5, d); check("R7 rx count at capacity", d, 4);
        rx_at(3, d); check("R7 last byte", d, 8'h83);
    endtask

    task automatic t_overrun;
        logic [7:0] d, mi;
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h05);
        sel(1'b0);
        for (int i = 0; i < 4; i++) xfer(8'h90 + 8'(i), mi);
        rd(3'd1, d); check("R7 closes when full", d, 8'h01);
        xfer(8'hEE, mi);
        rd(3'd1, d); check("R8 overrun on cap+1", d, 8'h05);
        xfer(8'hEF, mi);
        sel(1'b1);
        rd(3'd5, d); check("R8 count stays at cap", d, 4);
        rx_at(3, d); check("R8 data kept", d, 8'h93);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        wr(3'd2, 8'h00);
        check("R3 masked off", irq, 0);
        wr(3'd2, 8'h04);
        check("R3 overrun unmasked", irq, 1);
        wr(3'd1, 8'h04);
        rd(3'd1, d); check("R2 single clear", d, 8'h01);
        check("R3 irq after clear", irq, 0);
        wr(3'd2, 8'h01);
        check("R3 rx close unmasked", irq, 1);
        wr(3'd1, 8'hFF);
        rd(3'd1, d); check("R2 clear all", d, 0);
        check("R3 irq low after clear all", irq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_unarmed();
        t_early_deselect();
        t_exact_cap();
        t_overrun();
        t_irq();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule